// File: doc/BRIEF.md
# Framed SPI Master Shift Engine

This block is the serial core of an SPI master that moves 32-bit words whose payload may be one, two or four bytes long. Each transmit word arrives with a width code that fixes how many of its low-order bytes are real. Only those bytes go onto the wire, and the most significant real byte goes first. Each received word leaves the block right-justified, together with a count of the bytes it holds. This lets a transfer of any byte length pass through word-wide queues that sit outside the block.

Three traffic patterns are chosen with two path-disable inputs: full duplex, transmit only, and receive only. In receive-only mode the block has no transmit data to shift, so it makes clocks only on request. A request names a byte count, and MOSI is held low while those clocks run. An optional frame counter counts data bits against a programmed length and halts the engine when the length is reached, then pulses a completion flag. A programmable divider sets the SCK rate. Polarity, phase, bit order within a byte, and an internal MOSI-to-MISO loopback are all selectable.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, and whenever no word is being shifted, `busy`, `mosi` and `rx_valid` are 0 and `sck` equals `cfg_cpol`. In full-duplex mode with framing off, `tx_ready` is 1 in that state.
- R2: `tx_size` gives the byte-valid count of a transmit word: 0 means 1 byte (bits 7:0), 1 means 2 bytes (bits 15:0), and 2 or 3 means 4 bytes. Exactly 8 times that many bits are shifted.
- R3: Valid bytes go out highest-order valid byte first. Within a byte, bit 7 goes first when `cfg_lsb_first`=0, and bit 0 goes first when it is 1.
- R4: Every received word comes out on a one-cycle `rx_valid` pulse. `rx_bv` is between 1 and 4, the bytes are right-justified in `rx_data`, and the byte that arrived first sits highest. In full duplex, `rx_bv` equals the byte count of the transmit word.
- R5: `{cfg_tx_off,cfg_rx_off}` selects the mode: 00 is full duplex, 01 is transmit only (no `rx_valid` is ever raised), 10 is receive only (`tx_ready` stays 0), and 11 is off (no word starts).
- R6: `frame_start` loads a frame of `frame_len_m1`+1 bits, up to 4096 bits (512 bytes). While `frame_en`=1, the engine ends the current word after the last bit of the frame. A word cut short this way reports the bytes it completed. `frame_done` pulses for one cycle, in the cycle after the last bit. No further word starts until the next `frame_start`, and none starts at all while `frame_en`=1 and no frame has been loaded.
- R7: In receive-only mode, a request of N bytes (`rx_req_wr`) makes clocks for exactly N bytes, grouped into words of 4 bytes with any remainder in the last word. N above 32 is cut to 32. A request of 0, or a request made while earlier bytes are still pending, has no effect.
- R8: `busy` is 1 throughout the shifting of a word, including at every sampling edge.
- R9: Each SCK half-period lasts `cfg_div`+1 clock cycles, so bits are spaced 2*(`cfg_div`+1) cycles apart.
- R10: With `cfg_cpha`=0, data is sampled on the first SCK edge of each bit. With `cfg_cpha`=1, it is sampled on the second edge. MOSI changes only away from the sampling edges.
- R11: With `cfg_loopback`=1, received bits are taken from MOSI and `miso` is ignored. With `cfg_loopback`=0, they are taken from `miso`.
- R12: In receive-only mode, `mosi` stays 0 during all generated clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on first edge, 1: on second edge |
| cfg_lsb_first | input | 1 | Bit order inside each byte |
| cfg_loopback | input | 1 | Receive from MOSI instead of `miso` |
| cfg_tx_off | input | 1 | Disable transmit path |
| cfg_rx_off | input | 1 | Disable receive path |
| cfg_div | input | DIV_W | Half-period length minus one |
| frame_en | input | 1 | Enable frame length limit |
| frame_start | input | 1 | Load a new frame length |
| frame_len_m1 | input | FLEN_W | Frame length in bits minus one |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word accepted this cycle when valid |
| tx_data | input | WORD_W | Transmit word |
| tx_size | input | 2 | Width code of the transmit word |
| rx_req_wr | input | 1 | Receive-only request strobe |
| rx_req_bytes | input | REQ_W | Requested byte count |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | WORD_W | Received word, right-justified |
| rx_bv | output | BV_W | Valid bytes in `rx_data` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Word in flight |
| frame_done | output | 1 | Frame length reached |

## Verification
The bench sweeps every polarity, phase and bit-order combination against all three word widths, and checks both the decoded wire stream and the looped-back word. A wrong byte order or a wrong phase shows up as scrambled bits, and a bad width decode gives the wrong bit count. Frame tests cut a 4-byte word after 3 bytes, and run a full 4096-bit frame whose completion pulse must appear after the 128th word and not before. An off-by-one counter would end one word early or hang the interface. Receive-only tests cover remainder words, the 32-byte cap, ignored overlapping requests and a zero request. A counter that reloads mid-run, or one that does not saturate, produces an extra or missing word.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    typedef enum logic [1:0] {
        MODE_DUPLEX  = 2'd0,
        MODE_TX_ONLY = 2'd1,
        MODE_RX_ONLY = 2'd2,
        MODE_OFF     = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
        logic loopback;
    } spi_fmt_t;

    function automatic xfer_mode_e decode_mode(input logic tx_off, input logic rx_off);
        case ({tx_off, rx_off})
            2'b00:   return MODE_DUPLEX;
            2'b01:   return MODE_TX_ONLY;
            2'b10:   return MODE_RX_ONLY;
            default: return MODE_OFF;
        endcase
    endfunction

    function automatic logic [2:0] size_to_bv(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/spi_fm_divider.sv
module spi_fm_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_fm_framer.sv
module spi_fm_framer #(
    parameter int FLEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_en,
    input  logic              frame_start,
    input  logic [FLEN_W-1:0] len_m1,
    input  logic              bit_done,
    output logic              open_ok,
    output logic              stop,
    output logic              frame_done
);
    logic [FLEN_W:0] remaining;

    assign stop    = frame_en && bit_done && (remaining == (FLEN_W+1)'(1));
    assign open_ok = !frame_en || (remaining != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining  <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= stop;
            if (frame_start) begin
                remaining <= {1'b0, len_m1} + (FLEN_W+1)'(1);
            end else if (frame_en && bit_done && remaining != '0) begin
                remaining <= remaining - 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_fm_reqctr.sv
module spi_fm_reqctr #(
    parameter int BYTES   = 4,
    parameter int REQ_MAX = 32,
    parameter int REQ_W   = 6,
    parameter int BV_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REQ_W-1:0] bytes,
    input  logic             dec,
    output logic [REQ_W-1:0] pending,
    output logic [BV_W-1:0]  next_bv
);
    localparam logic [REQ_W-1:0] CAP   = REQ_W'(REQ_MAX);
    localparam logic [REQ_W-1:0] WBYTE = REQ_W'(BYTES);

    assign next_bv = (pending >= WBYTE) ? BV_W'(BYTES) : BV_W'(pending);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else if (wr && pending == '0) begin
            pending <= (bytes > CAP) ? CAP : bytes;
        end else if (dec && pending != '0) begin
            pending <= pending - 1'b1;
        end
    end
endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter
    import spi_fm_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int WORD_W = 8 * BYTES,
    localparam int BV_W   = $clog2(BYTES + 1),
    localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  spi_fmt_t          fmt,
    input  logic              tick,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic [BV_W-1:0]   load_bv,
    input  logic              rx_en,
    input  logic              rx_in,
    input  logic              stop,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              bit_done,
    output logic              byte_done,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    output logic [BV_W-1:0]   rx_bv
);
    logic              active;
    logic              half;
    logic [2:0]        bit_idx;
    logic [IDX_W-1:0]  byte_idx;
    logic [WORD_W-1:0] wd;
    logic [BV_W-1:0]   bv;
    logic [7:0]        rxb;
    logic [WORD_W-1:0] rxw;
    logic [7:0]        word_bytes [BYTES];
    logic [IDX_W-1:0]  cur_sel;
    logic [7:0]        cur_byte;
    logic              tx_bit;
    logic              last_byte;
    logic              word_end;
    logic [WORD_W-1:0] rxw_next;

    for (genvar g = 0; g < BYTES; g++) begin : g_bytes
        assign word_bytes[g] = wd[8*g +: 8];
    end

    assign cur_sel   = IDX_W'(bv - BV_W'(1) - BV_W'(byte_idx));
    assign cur_byte  = word_bytes[cur_sel];
    assign tx_bit    = fmt.lsb_first ? cur_byte[bit_idx] : cur_byte[3'd7 - bit_idx];
    assign last_byte = (BV_W'(byte_idx) == bv - BV_W'(1));
    assign bit_done  = active && tick && half;
    assign byte_done = bit_done && ((bit_idx == 3'd7) || stop);
    assign word_end  = byte_done && (last_byte || stop);
    assign rxw_next  = (rxw << 8) | WORD_W'(rxb);

    assign busy = active;
    assign mosi = active && tx_bit;
    assign sck  = active ? (fmt.cpol ^ (fmt.cpha ? ~half : half)) : fmt.cpol;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            half     <= 1'b0;
            bit_idx  <= '0;
            byte_idx <= '0;
            wd       <= '0;
            bv       <= '0;
            rxb      <= '0;
            rxw      <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_bv    <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!active) begin
                if (load) begin
                    active   <= 1'b1;
                    half     <= 1'b0;
                    bit_idx  <= '0;
                    byte_idx <= '0;
                    wd       <= load_data;
                    bv       <= load_bv;
                    rxw      <= '0;
                end
            end else if (tick) begin
                if (!half) begin
                    half <= 1'b1;
                    if (fmt.lsb_first) rxb[bit_idx] <= rx_in;
                    else               rxb[3'd7 - bit_idx] <= rx_in;
                end else begin
                    half <= 1'b0;
                    if (word_end) begin
                        active   <= 1'b0;
                        rx_valid <= rx_en;
                        rx_data  <= rxw_next;
                        rx_bv    <= BV_W'(byte_idx) + BV_W'(1);
                    end else if (byte_done) begin
                        byte_idx <= byte_idx + 1'b1;
                        bit_idx  <= '0;
                        rxw      <= rxw_next;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import spi_fm_pkg::*;
#(
    parameter int BYTES_PER_WORD  = 4,
    parameter int DIV_W           = 8,
    parameter int FRAME_MAX_BYTES = 512,
    parameter int REQ_MAX_BYTES   = 32,
    localparam int WORD_W = 8 * BYTES_PER_WORD,
    localparam int BV_W   = $clog2(BYTES_PER_WORD + 1),
    localparam int FLEN_W = $clog2(FRAME_MAX_BYTES * 8),
    localparam int REQ_W  = $clog2(REQ_MAX_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_loopback,
    input  logic              cfg_tx_off,
    input  logic              cfg_rx_off,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              frame_en,
    input  logic              frame_start,
    input  logic [FLEN_W-1:0] frame_len_m1,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [WORD_W-1:0] tx_data,
    input  logic [1:0]        tx_size,
    input  logic              rx_req_wr,
    input  logic [REQ_W-1:0]  rx_req_bytes,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    output logic [BV_W-1:0]   rx_bv,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              busy,
    output logic              frame_done
);
    spi_fmt_t          fmt;
    xfer_mode_e        mode;
    logic              tx_path;
    logic              rx_path;
    logic              can_start;
    logic              load;
    logic [WORD_W-1:0] load_data;
    logic [BV_W-1:0]   load_bv;
    logic              tick;
    logic              bit_done;
    logic              byte_done;
    logic              frame_open;
    logic              frame_stop;
    logic [REQ_W-1:0]  req_pending;
    logic [BV_W-1:0]   req_bv;
    logic              rx_in;

    assign fmt       = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first, loopback: cfg_loopback};
    assign mode      = decode_mode(cfg_tx_off, cfg_rx_off);
    assign tx_path   = (mode == MODE_DUPLEX) || (mode == MODE_TX_ONLY);
    assign rx_path   = (mode == MODE_DUPLEX) || (mode == MODE_RX_ONLY);
    assign can_start = !busy && frame_open;
    assign tx_ready  = can_start && tx_path;
    assign load      = tx_path ? (tx_valid && tx_ready)
                               : ((mode == MODE_RX_ONLY) && can_start && req_pending != '0);
    assign load_data = tx_path ? tx_data : '0;
    assign load_bv   = tx_path ? BV_W'(size_to_bv(tx_size)) : req_bv;
    assign rx_in     = fmt.loopback ? mosi : miso;

    spi_fm_divider #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (cfg_div),
        .tick (tick)
    );

    spi_fm_framer #(.FLEN_W(FLEN_W)) u_frm (
        .clk         (clk),
        .rst         (rst),
        .frame_en    (frame_en),
        .frame_start (frame_start),
        .len_m1      (frame_len_m1),
        .bit_done    (bit_done),
        .open_ok     (frame_open),
        .stop        (frame_stop),
        .frame_done  (frame_done)
    );

    spi_fm_reqctr #(
        .BYTES   (BYTES_PER_WORD),
        .REQ_MAX (REQ_MAX_BYTES),
        .REQ_W   (REQ_W),
        .BV_W    (BV_W)
    ) u_req (
        .clk     (clk),
        .rst     (rst),
        .wr      (rx_req_wr),
        .bytes   (rx_req_bytes),
        .dec     (byte_done && mode == MODE_RX_ONLY),
        .pending (req_pending),
        .next_bv (req_bv)
    );

    spi_fm_shifter #(.BYTES(BYTES_PER_WORD)) u_shf (
        .clk       (clk),
        .rst       (rst),
        .fmt       (fmt),
        .tick      (tick),
        .load      (load),
        .load_data (load_data),
        .load_bv   (load_bv),
        .rx_en     (rx_path),
        .rx_in     (rx_in),
        .stop      (frame_stop),
        .busy      (busy),
        .sck       (sck),
        .mosi      (mosi),
        .bit_done  (bit_done),
        .byte_done (byte_done),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_bv     (rx_bv)
    );
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_cpol,
    input logic       cfg_tx_off,
    input logic       cfg_rx_off,
    input logic       busy,
    input logic       sck,
    input logic       mosi,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       frame_done,
    input logic [2:0] rx_bv
);
    assert_idle_levels_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == cfg_cpol) && !mosi);

    assert_bv_range_R4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rx_bv >= 3'd1) && (rx_bv <= 3'd4));

    assert_no_rx_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(!cfg_rx_off));

    assert_ready_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !busy);

    assert_frame_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    assert_frame_done_ends_word_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $fell(busy));

    assert_rxonly_mosi_low_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_tx_off && !cfg_rx_off) |-> !mosi);
endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_cpol   (cfg_cpol),
    .cfg_tx_off (cfg_tx_off),
    .cfg_rx_off (cfg_rx_off),
    .busy       (busy),
    .sck        (sck),
    .mosi       (mosi),
    .tx_ready   (tx_ready),
    .rx_valid   (rx_valid),
    .frame_done (frame_done),
    .rx_bv      (rx_bv)
);

// File: tb/spi_frame_master_bench.sv
module spi_frame_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_loopback = 0;
    logic        cfg_tx_off = 0, cfg_rx_off = 0;
    logic [7:0]  cfg_div = 8'd1;
    logic        frame_en = 0, frame_start = 0;
    logic [11:0] frame_len_m1 = '0;
    logic        tx_valid = 0;
    logic        tx_ready;
    logic [31:0] tx_data = '0;
    logic [1:0]  tx_size = '0;
    logic        rx_req_wr = 0;
    logic [5:0]  rx_req_bytes = '0;
    logic        rx_valid;
    logic [31:0] rx_data;
    logic [2:0]  rx_bv;
    logic        sck, mosi, busy, frame_done;
    logic        miso = 0;

    spi_frame_master u_spi_frame_master (.*);

    always #5 clk = ~clk;

    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    bit mb [4200];
    int mcyc [4200];
    int mn = 0, idle_edges = 0;
    bit sb [512];
    bit mon_en = 0;
    logic [31:0] rxd [64];
    int rxb_a [64];
    int rn = 0, fdn = 0;

    always @(posedge clk) cyc++;

    always @(sck) begin
        if (mon_en && sck === (cfg_cpha ? cfg_cpol : ~cfg_cpol) && mn < 4200) begin
            mb[mn] = mosi;
            mcyc[mn] = cyc;
            if (!busy) idle_edges++;
            mn++;
            miso = sb[mn % 512];
        end
    end

    always @(negedge clk) begin
        if (rx_valid) begin
            if (rn < 64) begin
                rxd[rn] = rx_data;
                rxb_a[rn] = int'(rx_bv);
            end
            rn++;
        end
        if (frame_done) fdn++;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        if (cyc == 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] keep_bytes(input logic [31:0] d, input int bv);
        return (bv >= 4) ? d : d & ((32'h1 << (8 * bv)) - 32'h1);
    endfunction

    function automatic logic [7:0] pat_byte(input logic [7:0] seed, input int k);
        return seed + 8'(37 * k);
    endfunction

    task automatic check_stream(input int base, input logic [31:0] d, input int bv,
                                input bit lsb, input string req);
        int bad = 0;
        for (int k = 0; k < bv; k++) begin
            logic [7:0] b;
            b = d[(bv-1-k)*8 +: 8];
            for (int j = 0; j < 8; j++) begin
                if (mb[base + 8*k + j] !== (lsb ? b[j] : b[7-j])) bad++;
            end
        end
        check(bad == 0, req, "serial bit stream mismatches", bad, 0);
    endtask

    task automatic idle_wait();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic rearm();
        mn = 0;
        rn = 0;
        idle_edges = 0;
        miso = sb[0];
    endtask

    task automatic set_cfg(input bit cpol, input bit cpha, input bit lsb, input bit lb,
                           input bit txo, input bit rxo, input logic [7:0] dv);
        idle_wait();
        mon_en = 0;
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_loopback = lb;
        cfg_tx_off = txo; cfg_rx_off = rxo; cfg_div = dv;
        repeat (2) @(negedge clk);
        rearm();
        mon_en = 1;
    endtask

    task automatic send(input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d;
        tx_size = sz;
        tx_valid = 1;
        @(negedge clk);
        tx_valid = 0;
    endtask

    task automatic request(input int n);
        @(negedge clk);
        rx_req_bytes = 6'(n);
        rx_req_wr = 1;
        @(negedge clk);
        rx_req_wr = 0;
    endtask

    task automatic wait_rx(input int n);
        int t = 0;
        while (rn < n && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (40) @(negedge clk);
        idle_wait();
    endtask

    task automatic fill_sb(input bit lsb, input logic [7:0] seed);
        for (int k = 0; k < 64; k++) begin
            logic [7:0] b;
            b = pat_byte(seed, k);
            for (int j = 0; j < 8; j++) sb[8*k + j] = lsb ? b[j] : b[7-j];
        end
    endtask

    task automatic pulse_frame(input int bits);
        @(negedge clk);
        frame_len_m1 = 12'(bits - 1);
        frame_start = 1;
        @(negedge clk);
        frame_start = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(!busy, "R1", "busy after reset", busy, 0);
        check(sck == 1'b0, "R1", "sck after reset", sck, 0);
        check(!mosi, "R1", "mosi after reset", mosi, 0);
        check(!rx_valid && !frame_done, "R1", "strobes after reset", {rx_valid, frame_done}, 0);
        check(tx_ready, "R1", "tx_ready after reset", tx_ready, 1);

        // R2 R3 R4 R8 R10 R11: full sweep, loopback on, miso held high
        for (int k = 0; k < 512; k++) sb[k] = 1'b1;
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 4; s++) begin
                logic [31:0] d;
                int bv;
                d = 32'h9A3C_5E71 ^ (32'(c) * 32'h1111_0000) ^ (32'(s) * 32'h0102_0304);
                bv = (s == 0) ? 1 : (s == 1) ? 2 : 4;
                set_cfg(c[0], c[1], c[2], 1'b1, 1'b0, 1'b0, 8'd1);
                send(d, 2'(s));
                idle_wait();
                check(mn == 8 * bv, "R2", "bits shifted", mn, 8 * bv);
                check_stream(0, d, bv, c[2], "R3/R10");
                check(rn == 1, "R4", "rx words", rn, 1);
                check(rxd[0] == keep_bytes(d, bv), "R11", "looped rx data", rxd[0], keep_bytes(d, bv));
                check(rxb_a[0] == bv, "R4", "rx byte count", rxb_a[0], bv);
                check(idle_edges == 0, "R8", "sampling edges with busy low", idle_edges, 0);
                check(sck == c[0] && !busy, "R10", "sck idle level", sck, c[0]);
            end
        end

        // R11: loopback off takes miso
        for (int l = 0; l < 2; l++) begin
            fill_sb(l[0], 8'hC6);
            set_cfg(1'b0, 1'b1, l[0], 1'b0, 1'b0, 1'b0, 8'd2);
            send(32'h0000_1234, 2'd1);
            idle_wait();
            check(rxd[0] == {16'h0, pat_byte(8'hC6, 0), pat_byte(8'hC6, 1)}, "R11", "rx from miso",
                  rxd[0], {16'h0, pat_byte(8'hC6, 0), pat_byte(8'hC6, 1)});
            check_stream(0, 32'h1234, 2, l[0], "R3");
        end

        // R9: divider spacing
        for (int i = 0; i < 3; i++) begin
            int dv;
            dv = (i == 0) ? 0 : (i == 1) ? 2 : 5;
            set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'(dv));
            send(32'h5A, 2'd0);
            idle_wait();
            check(mcyc[1] - mcyc[0] == 2 * (dv + 1), "R9", "bit spacing", mcyc[1] - mcyc[0], 2 * (dv + 1));
            check(mcyc[7] - mcyc[0] == 14 * (dv + 1), "R9", "byte span", mcyc[7] - mcyc[0], 14 * (dv + 1));
        end

        // R6: framing
        set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0);
        frame_en = 1;
        @(negedge clk);
        check(!tx_ready, "R6", "ready with no frame loaded", tx_ready, 0);
        fdn = 0;
        pulse_frame(24);
        send(32'hDEAD_BEEF, 2'd2);
        idle_wait();
        check(mn == 24, "R6", "bits in short frame", mn, 24);
        check(rn == 1 && rxd[0] == 32'h00DE_ADBE, "R6", "cut word data", rxd[0], 32'h00DE_ADBE);
        check(rxb_a[0] == 3, "R6", "cut word byte count", rxb_a[0], 3);
        check(fdn == 1, "R6", "frame_done pulses", fdn, 1);
        check(!tx_ready, "R6", "ready after frame end", tx_ready, 0);
        pulse_frame(4096);
        rearm();
        fdn = 0;
        for (int w = 0; w < 127; w++) send(32'h1357_9BDF + 32'(w), 2'd2);
        idle_wait();
        check(fdn == 0, "R6", "early frame_done", fdn, 0);
        check(tx_ready, "R6", "ready inside long frame", tx_ready, 1);
        send(32'hFACE_0042, 2'd2);
        idle_wait();
        check(fdn == 1, "R6", "frame_done at 512 bytes", fdn, 1);
        check(mn == 4096, "R6", "bits in max frame", mn, 4096);
        check(!tx_ready, "R6", "ready after max frame", tx_ready, 0);
        frame_en = 0;

        // R7 R12: receive only
        for (int l = 0; l < 2; l++) begin
            fill_sb(l[0], 8'h5A);
            set_cfg(1'b1, l[0], l[0], 1'b0, 1'b1, 1'b0, 8'd0);
            check(!tx_ready, "R5", "tx_ready in receive-only", tx_ready, 0);
            request(6);
            wait_rx(2);
            check(rn == 2, "R7", "words for 6 bytes", rn, 2);
            check(mn == 48, "R7", "clocks for 6 bytes", mn, 48);
            check(rxd[0] == {pat_byte(8'h5A, 0), pat_byte(8'h5A, 1), pat_byte(8'h5A, 2), pat_byte(8'h5A, 3)},
                  "R7", "first rx word", rxd[0],
                  {pat_byte(8'h5A, 0), pat_byte(8'h5A, 1), pat_byte(8'h5A, 2), pat_byte(8'h5A, 3)});
            check(rxb_a[0] == 4 && rxb_a[1] == 2, "R7", "rx byte counts", {rxb_a[0][15:0], rxb_a[1][15:0]}, 32'h0004_0002);
            check(rxd[1] == {16'h0, pat_byte(8'h5A, 4), pat_byte(8'h5A, 5)}, "R7", "remainder word",
                  rxd[1], {16'h0, pat_byte(8'h5A, 4), pat_byte(8'h5A, 5)});
            begin
                int ones = 0;
                for (int k = 0; k < 48; k++) if (mb[k]) ones++;
                check(ones == 0, "R12", "mosi high bits in receive-only", ones, 0);
            end
        end
        rearm();
        request(40);
        wait_rx(8);
        check(rn == 8 && mn == 256, "R7", "capped request bits", mn, 256);
        rearm();
        request(8);
        request(4);
        wait_rx(2);
        check(rn == 2 && mn == 64, "R7", "overlapping request ignored", mn, 64);
        rearm();
        request(0);
        repeat (30) @(negedge clk);
        check(rn == 0 && mn == 0 && !busy, "R7", "zero request", mn, 0);

        // R5: transmit only and off
        set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd1);
        send(32'hC001_D00D, 2'd3);
        idle_wait();
        check(rn == 0, "R5", "rx words in transmit-only", rn, 0);
        check(mn == 32, "R5", "bits in transmit-only", mn, 32);
        check_stream(0, 32'hC001_D00D, 4, 1'b0, "R5");
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd1);
        request(4);
        repeat (30) @(negedge clk);
        check(!tx_ready && !busy && mn == 0, "R5", "mode off starts nothing", mn, 0);

        summary();
        $finish;
    end
endmodule